// File: doc/BRIEF.md
# Register Alias Table Renamer

This block renames the register operands of decoded micro-operations before they enter the out-of-order core. It keeps one entry per architectural register. Each entry is either empty, or it holds the reorder-buffer slot number of the newest in-flight uop that will write that register. One uop is accepted per cycle. It carries a set of source register indices, each with its own enable, an optional destination index, and the reorder-buffer slot allocated to it. For each source the block returns one of two results. The first is the slot number of the producing uop. The second is a marker that tells the consumer to read the committed architectural register file.

Retirement notifications come in on a separate pair of inputs. When a slot retires, any entry still naming that slot goes empty. An entry that a younger writer has already taken over stays as it is. Table lookups use the state from before the accepting cycle's own destination update. This gives reads-before-write ordering within a single uop. A lookup that hits a slot retiring in the same cycle falls back to the architectural file. Results come out through an optional output register, selected by a parameter.

Top module: `rat_renamer`

## Requirements
- R1: After reset every architectural register is unmapped, so every enabled source reports the architectural-file marker (`out_src_arch` bit = 1) with tag 0, and `out_valid` is 0.
- R2: When an accepted uop (`in_valid`=1, `in_dst_en`=1) names destination d with slot t, a later accepted uop reading d gets `out_src_arch`=0 and `out_src_tag`=t. This holds for every slot value, including the highest one.
- R3: A younger writer of the same register replaces the older mapping, and later readers see only the younger slot.
- R4: A uop whose source and destination name the same register gets the mapping that was in the table before that uop. Its own slot becomes visible only to later uops.
- R5: A retire notification (`ret_valid`=1, `ret_tag`=t) empties every entry that currently holds t. Later reads of such a register return the architectural-file marker.
- R6: A retire notification for a slot that no entry currently holds leaves every mapping unchanged.
- R7: A lookup that hits an entry whose slot is retiring in the same cycle reports the architectural-file marker.
- R8: With the default output register, the results for a uop appear one clock after it is accepted, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 one clock later.
- R9: A source with its enable bit at 0 reports the architectural-file marker and tag 0, whatever the table holds.
- R10: When `in_valid`=0, the destination inputs are ignored and no mapping changes.
- R11: If the same cycle both writes register d and retires the slot that d currently holds, the new writer's slot is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A uop is presented for renaming this cycle |
| in_src_en | input | NUM_SRC | Per-source enable |
| in_src_idx | input | NUM_SRC x ARCH_W | Per-source architectural register index |
| in_dst_en | input | 1 | The uop writes a destination register |
| in_dst_idx | input | ARCH_W | Destination architectural register index |
| in_rob_tag | input | TAG_W | Reorder-buffer slot allocated to the uop |
| ret_valid | input | 1 | A reorder-buffer slot retires this cycle |
| ret_tag | input | TAG_W | Retiring slot number |
| out_valid | output | 1 | Renamed results are valid |
| out_src_arch | output | NUM_SRC | 1 = read the architectural file, 0 = wait on the slot |
| out_src_tag | output | NUM_SRC x TAG_W | Producer slot per source (0 when the marker is set) |

## Verification
The bench targets these corner cases:
- **Same-uop read and write (R4).** A design that updated the table before the lookup would hand a uop its own slot as a source and deadlock it.
- **Stale retirement (R6).** A design that cleared entries by register instead of by slot comparison would drop a younger writer's mapping. Consumers would then read a stale committed value.
- **Retire during lookup (R7).** A design without the same-cycle check would make a consumer wait on a slot that has already left the buffer.
- **Write racing retire (R11).** A design where the clear won would lose the new producer.
- **Slot value 31, idle cycles, disabled sources.** These catch truncated tags, writes leaking through when `in_valid` is low, and garbage tags on unused operands.

// File: rtl/rat_pkg.sv
package rat_pkg;

   // Where a renamed operand obtains its value.
   typedef enum logic {
      OPND_ROB  = 1'b0,
      OPND_ARCH = 1'b1
   } opnd_src_e;

   // Bit width needed to index n items, never below one.
   function automatic int idx_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction

endpackage

// File: rtl/rat_map_entry.sv
module rat_map_entry #(
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             clr_en,
   input  logic [TAG_W-1:0] clr_tag,
   output logic             mapped,
   output logic [TAG_W-1:0] tag
);

   logic clr_hit;

   // Clear only when this entry still names the retiring slot.
   assign clr_hit = clr_en && mapped && (tag == clr_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mapped <= 1'b0;
         tag    <= '0;
      end else if (wr_en) begin
         mapped <= 1'b1;
         tag    <= wr_tag;
      end else if (clr_hit) begin
         mapped <= 1'b0;
      end
   end

   p_write_maps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mapped && tag == $past(wr_tag)));

   p_write_beats_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_en) |=> mapped);

   p_retire_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && clr_en && mapped && tag == clr_tag) |=> !mapped);

   p_foreign_retire_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(clr_en && tag == clr_tag)) |=> ($stable(mapped) && $stable(tag)));

endmodule

// File: rtl/rat_src_port.sv
module rat_src_port
   import rat_pkg::*;
#(
   parameter int NUM_ARCH = 16,
   parameter int TAG_W    = 5,
   parameter int ARCH_W   = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [ARCH_W-1:0]                idx,
   input  logic [NUM_ARCH-1:0]              map_vld,
   input  logic [NUM_ARCH-1:0][TAG_W-1:0]   map_tag,
   input  logic                             ret_vld,
   input  logic [TAG_W-1:0]                 ret_tag,
   output logic                             from_arch,
   output logic [TAG_W-1:0]                 out_tag
);

   logic             in_range;
   logic             sel_vld;
   logic [TAG_W-1:0] sel_tag;
   logic             retiring;
   opnd_src_e        kind;

   always_comb begin
      in_range = (32'(idx) < NUM_ARCH);
      sel_vld  = 1'b0;
      sel_tag  = '0;
      for (int r = 0; r < NUM_ARCH; r++) begin
         if (idx == ARCH_W'(r)) begin
            sel_vld = map_vld[r];
            sel_tag = map_tag[r];
         end
      end
      retiring = ret_vld && (sel_tag == ret_tag);
      if (!en || !in_range || !sel_vld || retiring) begin
         kind    = OPND_ARCH;
         out_tag = '0;
      end else begin
         kind    = OPND_ROB;
         out_tag = sel_tag;
      end
      from_arch = (kind == OPND_ARCH);
   end

   p_disabled_src_arch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (from_arch && out_tag == '0));

   p_retiring_hit_arch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld && map_vld[idx] && map_tag[idx] == ret_tag) |-> from_arch);

   p_live_hit_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!from_arch) |-> (map_vld[idx] && out_tag == map_tag[idx]));

endmodule

// File: rtl/rat_out_stage.sv
module rat_out_stage #(
   parameter int W       = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_vld  <= 1'b0;
               out_data <= '0;
            end else begin
               out_vld  <= in_vld;
               out_data <= in_data;
            end
         end

         p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld);

         p_idle_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld);
      end else begin : g_comb
         assign out_vld  = in_vld;
         assign out_data = in_data;
      end
   endgenerate

endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
   import rat_pkg::*;
#(
   parameter int NUM_ARCH  = 16,
   parameter int ROB_DEPTH = 32,
   parameter int NUM_SRC   = 2,
   parameter bit OUT_REG   = 1'b1,
   localparam int ARCH_W   = idx_bits(NUM_ARCH),
   localparam int TAG_W    = idx_bits(ROB_DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [NUM_SRC-1:0]              in_src_en,
   input  logic [NUM_SRC-1:0][ARCH_W-1:0]  in_src_idx,
   input  logic                            in_dst_en,
   input  logic [ARCH_W-1:0]               in_dst_idx,
   input  logic [TAG_W-1:0]                in_rob_tag,
   input  logic                            ret_valid,
   input  logic [TAG_W-1:0]                ret_tag,
   output logic                            out_valid,
   output logic [NUM_SRC-1:0]              out_src_arch,
   output logic [NUM_SRC-1:0][TAG_W-1:0]   out_src_tag
);

   localparam int SLICE_W = TAG_W + 1;
   localparam int PACK_W  = NUM_SRC * SLICE_W;

   generate
      if (NUM_ARCH < 2)                 begin : g_bad_arch $error("NUM_ARCH must be at least 2"); end
      if (ROB_DEPTH < 2)                begin : g_bad_rob  $error("ROB_DEPTH must be at least 2"); end
      if (NUM_SRC < 1 || NUM_SRC > 4)   begin : g_bad_src  $error("NUM_SRC must be 1 to 4"); end
   endgenerate

   logic [NUM_ARCH-1:0]             map_vld;
   logic [NUM_ARCH-1:0][TAG_W-1:0]  map_tag;
   logic [NUM_ARCH-1:0]             wr_sel;
   logic [NUM_SRC-1:0]              lk_arch;
   logic [NUM_SRC-1:0][TAG_W-1:0]   lk_tag;
   logic [PACK_W-1:0]               lk_pack;
   logic [PACK_W-1:0]               res_pack;

   // Table entries: one per architectural register.
   genvar r;
   generate
      for (r = 0; r < NUM_ARCH; r++) begin : g_ent
         assign wr_sel[r] = in_valid && in_dst_en && (in_dst_idx == ARCH_W'(r));

         rat_map_entry #(.TAG_W(TAG_W)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[r]),
            .wr_tag  (in_rob_tag),
            .clr_en  (ret_valid),
            .clr_tag (ret_tag),
            .mapped  (map_vld[r]),
            .tag     (map_tag[r])
         );
      end
   endgenerate

   // Lookups read the table as it stood before this cycle's update.
   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_src
         rat_src_port #(
            .NUM_ARCH (NUM_ARCH),
            .TAG_W    (TAG_W),
            .ARCH_W   (ARCH_W)
         ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (in_src_en[s]),
            .idx       (in_src_idx[s]),
            .map_vld   (map_vld),
            .map_tag   (map_tag),
            .ret_vld   (ret_valid),
            .ret_tag   (ret_tag),
            .from_arch (lk_arch[s]),
            .out_tag   (lk_tag[s])
         );

         assign lk_pack[s*SLICE_W +: SLICE_W] = {lk_arch[s], lk_tag[s]};
         assign out_src_arch[s] = res_pack[s*SLICE_W + TAG_W];
         assign out_src_tag[s]  = res_pack[s*SLICE_W +: TAG_W];
      end
   endgenerate

   rat_out_stage #(.W(PACK_W), .OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_valid),
      .in_data  (lk_pack),
      .out_vld  (out_valid),
      .out_data (res_pack)
   );

   p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !ret_valid) |=> ($stable(map_vld) && $stable(map_tag)));

   p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   p_reset_empty_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (map_vld == '0));

endmodule

// File: tb/sim_rat_renamer.sv
`timescale 1ns/1ps
module sim_rat_renamer;

   localparam int NA = 16;
   localparam int RD = 32;
   localparam int NS = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [NS-1:0]    in_src_en;
   logic [NS-1:0][3:0] in_src_idx;
   logic             in_dst_en;
   logic [3:0]       in_dst_idx;
   logic [4:0]       in_rob_tag;
   logic             ret_valid;
   logic [4:0]       ret_tag;
   logic             out_valid;
   logic [NS-1:0]    out_src_arch;
   logic [NS-1:0][4:0] out_src_tag;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rat_renamer #(.NUM_ARCH(NA), .ROB_DEPTH(RD), .NUM_SRC(NS), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_en(in_src_en),
      .in_src_idx(in_src_idx), .in_dst_en(in_dst_en), .in_dst_idx(in_dst_idx),
      .in_rob_tag(in_rob_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
      .out_valid(out_valid), .out_src_arch(out_src_arch), .out_src_tag(out_src_tag)
   );

   task automatic issue(input bit e0, input int s0, input bit e1, input int s1,
                        input bit de, input int d, input int t,
                        input bit rv, input int rt);
      in_valid      = 1'b1;
      in_src_en[0]  = e0;  in_src_idx[0] = 4'(s0);
      in_src_en[1]  = e1;  in_src_idx[1] = 4'(s1);
      in_dst_en     = de;  in_dst_idx    = 4'(d);
      in_rob_tag    = 5'(t);
      ret_valid     = rv;  ret_tag       = 5'(rt);
      @(posedge clk); #1;
   endtask

   task automatic idle(input bit de, input int d, input int t, input bit rv, input int rt);
      in_valid   = 1'b0;
      in_src_en  = '0;
      in_dst_en  = de; in_dst_idx = 4'(d); in_rob_tag = 5'(t);
      ret_valid  = rv; ret_tag    = 5'(rt);
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input int s, input bit ea, input int et);
      total++;
      if (out_valid !== 1'b1 || out_src_arch[s] !== ea || out_src_tag[s] !== 5'(et)) begin
         bad++;
         $display("FAIL %s src%0d: got valid=%0b arch=%0b tag=%0d, expected valid=1 arch=%0b tag=%0d",
                  req, s, out_valid, out_src_arch[s], out_src_tag[s], ea, et);
      end
   endtask

   task automatic chk_vld(input string req, input bit ev);
      total++;
      if (out_valid !== ev) begin
         bad++;
         $display("FAIL %s: got out_valid=%0b, expected %0b", req, out_valid, ev);
      end
   endtask

   task automatic t_reset();
      chk_vld("R1 valid after reset", 1'b0);
      for (int r = 0; r < NA; r += 2) begin
         issue(1, r, 1, r + 1, 0, 0, 0, 0, 0);
         chk("R1", 0, 1'b1, 0);
         chk("R1", 1, 1'b1, 0);
      end
   endtask

   task automatic t_map_basic();
      issue(0, 0, 0, 0, 1, 3, 5, 0, 0);
      issue(1, 3, 1, 2, 0, 0, 0, 0, 0);
      chk("R2", 0, 1'b0, 5);
      chk("R2", 1, 1'b1, 0);
      issue(0, 0, 0, 0, 1, 15, 31, 0, 0);
      issue(0, 0, 1, 15, 0, 0, 0, 0, 0);
      chk("R2 top slot", 1, 1'b0, 31);
   endtask

   task automatic t_overwrite();
      issue(0, 0, 0, 0, 1, 3, 6, 0, 0);
      issue(1, 3, 0, 0, 0, 0, 0, 0, 0);
      chk("R3", 0, 1'b0, 6);
   endtask

   task automatic t_self_read();
      issue(0, 0, 0, 0, 1, 1, 4, 0, 0);
      issue(1, 1, 1, 0, 1, 1, 7, 0, 0);
      chk("R4 old producer", 0, 1'b0, 4);
      chk("R4 other src", 1, 1'b1, 0);
      issue(1, 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 later reader", 0, 1'b0, 7);
   endtask

   task automatic t_retire_match();
      idle(0, 0, 0, 1, 7);
      chk_vld("R8 idle", 1'b0);
      issue(1, 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R5", 0, 1'b1, 0);
   endtask

   task automatic t_retire_stale();
      idle(0, 0, 0, 1, 5);
      issue(1, 3, 0, 0, 0, 0, 0, 0, 0);
      chk("R6", 0, 1'b0, 6);
   endtask

   task automatic t_retire_same_cycle();
      issue(1, 3, 1, 15, 0, 0, 0, 1, 6);
      chk("R7", 0, 1'b1, 0);
      chk("R7 other", 1, 1'b0, 31);
      issue(1, 3, 0, 0, 0, 0, 0, 0, 0);
      chk("R5 after", 0, 1'b1, 0);
   endtask

   task automatic t_disabled();
      issue(0, 0, 0, 0, 1, 2, 12, 0, 0);
      issue(0, 2, 1, 2, 0, 0, 0, 0, 0);
      chk("R9", 0, 1'b1, 0);
      chk("R9 enabled", 1, 1'b0, 12);
   endtask

   task automatic t_idle_dst();
      idle(1, 9, 9, 0, 0);
      chk_vld("R8 idle", 1'b0);
      issue(1, 9, 0, 0, 0, 0, 0, 0, 0);
      chk("R10", 0, 1'b1, 0);
      chk_vld("R8 accept", 1'b1);
   endtask

   task automatic t_write_beats_retire();
      issue(0, 0, 0, 0, 1, 5, 10, 0, 0);
      issue(0, 0, 0, 0, 1, 5, 11, 1, 10);
      issue(1, 5, 0, 0, 0, 0, 0, 0, 0);
      chk("R11", 0, 1'b0, 11);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got no end, expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_src_en = '0; in_src_idx = '0;
      in_dst_en = 1'b0; in_dst_idx = '0; in_rob_tag = '0;
      ret_valid = 1'b0; ret_tag = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_map_basic();
      t_overwrite();
      t_self_read();
      t_retire_match();
      t_retire_stale();
      t_retire_same_cycle();
      t_disabled();
      t_idle_dst();
      t_write_beats_retire();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule